// File: doc/BRIEF.md
# UART Register Bank with Banked Divisor Access

This block is the host-facing register file of a 16550-style UART. A simple memory-mapped bus supplies an address, a write enable, a read enable and a write byte, and receives a read byte. Eight byte-wide register slots sit 8 bytes apart. The slot number comes from address bits [5:3]. Bit 7 of the line control register is the bank bit. It switches slots 0, 1 and 2 between the data, interrupt-enable and identification/FIFO-control registers and a second set: the two divisor bytes and an alternate-function register.

The bank stores the line control, modem control, interrupt enable, scratch, alternate-function and FIFO-enable values and drives them as configuration outputs. It loads the 16-bit baud divisor as one value when its low byte is written. It sends one-cycle strobes to the neighbouring engines: a push with its byte to the transmitter, a pop to the receiver, and a clear for each FIFO. It returns the receive byte and the status bytes that those engines supply on its inputs.

Top module: `uartreg_bank`

## Requirements
- R1: After reset, int_enable, line_ctrl, modem_ctrl, alt_func, baud_div, fifo_enable, tx_byte, bus_rdata and all four strobes are zero.
- R2: The slot is bus_addr[5:3]. Address bits [2:0] and every bit above bit 5 have no effect on which register is accessed.
- R3: With the bank bit (line_ctrl[7]) clear, a read of slot 0 returns rx_byte and pulses rx_pop for one cycle. A write of slot 0 loads tx_byte with the write data and pulses tx_push for one cycle.
- R4: With the bank bit set, slot 0 reads and writes the low divisor byte, and rx_pop and tx_push stay low.
- R5: Slot 1 is the read/write interrupt enable register when the bank bit is clear. When the bank bit is set, slot 1 is a read/write staging byte for the divisor high byte, and int_enable is left unchanged.
- R6: baud_div changes only on a slot 0 write with the bank bit set, and then becomes {staged high byte, written byte}. A high-byte write alone leaves baud_div unchanged.
- R7: With the bank bit clear, a read of slot 2 returns irq_id. A write of slot 2 sets fifo_enable to data bit 0. Data bit 1 pulses rxf_clear and data bit 2 pulses txf_clear, each for one cycle, and neither bit is stored.
- R8: With the bank bit set, slot 2 is the read/write alt_func register. A write there leaves fifo_enable unchanged and produces no clear strobe.
- R9: Slot 3 (line control), slot 4 (modem control) and slot 7 (scratch) are read/write in both banks.
- R10: A read of slot 5 returns line_stat and a read of slot 6 returns modem_stat. Writes to slots 5 and 6 change no stored register and no output.
- R11: bus_rdata is registered. It holds the value read in the cycle after the read, and it keeps that value while bus_rd is low. Every strobe lasts exactly one cycle after the access that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits [5:3] select the slot |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_byte | input | 8 | Head byte from the receiver |
| irq_id | input | 8 | Identification byte from the interrupt logic |
| line_stat | input | 8 | Line status byte |
| modem_stat | input | 8 | Modem status byte |
| rx_pop | output | 1 | One-cycle receive pop strobe |
| tx_push | output | 1 | One-cycle transmit push strobe |
| tx_byte | output | 8 | Byte that goes with tx_push |
| rxf_clear | output | 1 | One-cycle receive FIFO clear |
| txf_clear | output | 1 | One-cycle transmit FIFO clear |
| fifo_enable | output | 1 | FIFO enable |
| int_enable | output | 8 | Interrupt enable register |
| line_ctrl | output | 8 | Line control register; bit 7 is the bank bit |
| modem_ctrl | output | 8 | Modem control register |
| alt_func | output | 8 | Alternate-function register |
| baud_div | output | 16 | Committed baud divisor |

## Verification
Every result of an access is due one clock edge after the edge that samples the access. This covers read data, the strobes and every configuration register, including a bank-bit change, which governs decoding only from the next access. The bench drives each access at a falling edge and samples all outputs 1 ns after the following rising edge. It samples an idle cycle there too, to confirm that strobes have dropped and read data is holding. A read and a write in the same cycle return the value from before the write, and the bench model computes its expected read data before it applies the write.

// File: rtl/uartreg_pkg.sv
package uartreg_pkg;

   typedef enum logic [2:0] {
      SLOT_DATA  = 3'd0,
      SLOT_IEN   = 3'd1,
      SLOT_IDFC  = 3'd2,
      SLOT_LINE  = 3'd3,
      SLOT_MODEM = 3'd4,
      SLOT_LSTAT = 3'd5,
      SLOT_MSTAT = 3'd6,
      SLOT_SCR   = 3'd7
   } slot_e;

   typedef struct packed {
      logic thr_wr;
      logic dll_wr;
      logic dlm_wr;
      logic ier_wr;
      logic fcr_wr;
      logic afr_wr;
      logic lcr_wr;
      logic mcr_wr;
      logic scr_wr;
      logic rbr_rd;
   } acc_t;

   localparam int unsigned SLOT_BITS = 3;
   localparam int unsigned BANK_BIT  = 7;
   localparam int unsigned FEN_BIT   = 0;
   localparam int unsigned RCLR_BIT  = 1;
   localparam int unsigned TCLR_BIT  = 2;

endpackage

// File: rtl/uartreg_decode.sv
module uartreg_decode
   import uartreg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned SLOT_LSB = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic              bank,
   output slot_e             slot,
   output acc_t              acc
);

   always_comb begin
      slot = slot_e'(addr[SLOT_LSB +: SLOT_BITS]);
      acc  = '0;
      unique case (slot)
         SLOT_DATA: begin
            acc.thr_wr = wr & ~bank;
            acc.dll_wr = wr &  bank;
            acc.rbr_rd = rd & ~bank;
         end
         SLOT_IEN: begin
            acc.ier_wr = wr & ~bank;
            acc.dlm_wr = wr &  bank;
         end
         SLOT_IDFC: begin
            acc.fcr_wr = wr & ~bank;
            acc.afr_wr = wr &  bank;
         end
         SLOT_LINE:  acc.lcr_wr = wr;
         SLOT_MODEM: acc.mcr_wr = wr;
         SLOT_SCR:   acc.scr_wr = wr;
         default: ;
      endcase
   end

endmodule

// File: rtl/uartreg_cfg.sv
module uartreg_cfg
   import uartreg_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned DIV_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_t              acc,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ier_q,
   output logic [DATA_W-1:0] lcr_q,
   output logic [DATA_W-1:0] mcr_q,
   output logic [DATA_W-1:0] scr_q,
   output logic [DATA_W-1:0] afr_q,
   output logic [DATA_W-1:0] div_stage_q,
   output logic [DIV_W-1:0]  div_q,
   output logic              fen_q,
   output logic [DATA_W-1:0] txb_q,
   output logic              push_q,
   output logic              pop_q,
   output logic              rclr_q,
   output logic              tclr_q
);

   // plain read/write registers share one template
   localparam int unsigned NPLAIN = 5;
   logic [NPLAIN-1:0]             plain_we;
   logic [NPLAIN-1:0][DATA_W-1:0] plain_q;

   assign plain_we = {acc.afr_wr, acc.scr_wr, acc.mcr_wr, acc.lcr_wr, acc.ier_wr};

   for (genvar gi = 0; gi < NPLAIN; gi++) begin : g_plain
      always_ff @(posedge clk) begin
         if (!rst_n)           plain_q[gi] <= '0;
         else if (plain_we[gi]) plain_q[gi] <= wdata;
      end
   end

   assign ier_q = plain_q[0];
   assign lcr_q = plain_q[1];
   assign mcr_q = plain_q[2];
   assign scr_q = plain_q[3];
   assign afr_q = plain_q[4];

   // divisor: high byte staged, whole value committed on low-byte write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_stage_q <= '0;
         div_q       <= '0;
      end else begin
         if (acc.dlm_wr) div_stage_q <= wdata;
         if (acc.dll_wr) div_q       <= {div_stage_q, wdata};
      end
   end

   // FIFO control: only the enable is kept
   always_ff @(posedge clk) begin
      if (!rst_n)          fen_q <= 1'b0;
      else if (acc.fcr_wr) fen_q <= wdata[FEN_BIT];
   end

   // transmit byte capture
   always_ff @(posedge clk) begin
      if (!rst_n)          txb_q <= '0;
      else if (acc.thr_wr) txb_q <= wdata;
   end

   // one-cycle strobes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         push_q <= 1'b0;
         pop_q  <= 1'b0;
         rclr_q <= 1'b0;
         tclr_q <= 1'b0;
      end else begin
         push_q <= acc.thr_wr;
         pop_q  <= acc.rbr_rd;
         rclr_q <= acc.fcr_wr & wdata[RCLR_BIT];
         tclr_q <= acc.fcr_wr & wdata[TCLR_BIT];
      end
   end

endmodule

// File: rtl/uartreg_rdmux.sv
module uartreg_rdmux
   import uartreg_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter bit          RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  slot_e             slot,
   input  logic              bank,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] irq_id,
   input  logic [DATA_W-1:0] line_stat,
   input  logic [DATA_W-1:0] modem_stat,
   input  logic [DATA_W-1:0] ier_q,
   input  logic [DATA_W-1:0] lcr_q,
   input  logic [DATA_W-1:0] mcr_q,
   input  logic [DATA_W-1:0] scr_q,
   input  logic [DATA_W-1:0] afr_q,
   input  logic [DATA_W-1:0] div_lo,
   input  logic [DATA_W-1:0] div_stage,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] rd_next;

   always_comb begin
      unique case (slot)
         SLOT_DATA:  rd_next = bank ? div_lo    : rx_byte;
         SLOT_IEN:   rd_next = bank ? div_stage : ier_q;
         SLOT_IDFC:  rd_next = bank ? afr_q     : irq_id;
         SLOT_LINE:  rd_next = lcr_q;
         SLOT_MODEM: rd_next = mcr_q;
         SLOT_LSTAT: rd_next = line_stat;
         SLOT_MSTAT: rd_next = modem_stat;
         SLOT_SCR:   rd_next = scr_q;
         default:    rd_next = '0;
      endcase
   end

   if (RD_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)  rdata <= '0;
         else if (rd) rdata <= rd_next;
      end
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst_n ^ rd;
      assign rdata     = rd_next;
   end

endmodule

// File: rtl/uartreg_bank.sv
module uartreg_bank
   import uartreg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned SLOT_LSB = 3,
   parameter bit          RD_REG   = 1'b1,
   localparam int unsigned DIV_W   = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] irq_id,
   input  logic [DATA_W-1:0] line_stat,
   input  logic [DATA_W-1:0] modem_stat,
   output logic              rx_pop,
   output logic              tx_push,
   output logic [DATA_W-1:0] tx_byte,
   output logic              rxf_clear,
   output logic              txf_clear,
   output logic              fifo_enable,
   output logic [DATA_W-1:0] int_enable,
   output logic [DATA_W-1:0] line_ctrl,
   output logic [DATA_W-1:0] modem_ctrl,
   output logic [DATA_W-1:0] alt_func,
   output logic [DIV_W-1:0]  baud_div
);

   if (DATA_W != 8) begin : g_bad_data_w
      $error("uartreg_bank: DATA_W must be 8");
   end
   if (ADDR_W < SLOT_LSB + SLOT_BITS) begin : g_bad_addr_w
      $error("uartreg_bank: ADDR_W too small for slot field");
   end

   slot_e             slot;
   acc_t              acc;
   logic              bank;
   logic [DATA_W-1:0] scr_q;
   logic [DATA_W-1:0] div_stage_q;

   assign bank = line_ctrl[BANK_BIT];

   uartreg_decode #(
      .ADDR_W   (ADDR_W),
      .SLOT_LSB (SLOT_LSB)
   ) u_decode (
      .addr (bus_addr),
      .wr   (bus_wr),
      .rd   (bus_rd),
      .bank (bank),
      .slot (slot),
      .acc  (acc)
   );

   uartreg_cfg #(
      .DATA_W (DATA_W)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc         (acc),
      .wdata       (bus_wdata),
      .ier_q       (int_enable),
      .lcr_q       (line_ctrl),
      .mcr_q       (modem_ctrl),
      .scr_q       (scr_q),
      .afr_q       (alt_func),
      .div_stage_q (div_stage_q),
      .div_q       (baud_div),
      .fen_q       (fifo_enable),
      .txb_q       (tx_byte),
      .push_q      (tx_push),
      .pop_q       (rx_pop),
      .rclr_q      (rxf_clear),
      .tclr_q      (txf_clear)
   );

   uartreg_rdmux #(
      .DATA_W (DATA_W),
      .RD_REG (RD_REG)
   ) u_rdmux (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd         (bus_rd),
      .slot       (slot),
      .bank       (bank),
      .rx_byte    (rx_byte),
      .irq_id     (irq_id),
      .line_stat  (line_stat),
      .modem_stat (modem_stat),
      .ier_q      (int_enable),
      .lcr_q      (line_ctrl),
      .mcr_q      (modem_ctrl),
      .scr_q      (scr_q),
      .afr_q      (alt_func),
      .div_lo     (baud_div[DATA_W-1:0]),
      .div_stage  (div_stage_q),
      .rdata      (bus_rdata)
   );

endmodule

// File: rtl/uartreg_bank_chk.sv
module uartreg_bank_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned SLOT_LSB = 3,
   parameter bit          RD_REG   = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic                rx_pop,
   input logic                tx_push,
   input logic                rxf_clear,
   input logic                txf_clear,
   input logic                fifo_enable,
   input logic [DATA_W-1:0]   int_enable,
   input logic [DATA_W-1:0]   line_ctrl,
   input logic [DATA_W-1:0]   modem_ctrl,
   input logic [DATA_W-1:0]   alt_func,
   input logic [2*DATA_W-1:0] baud_div
);

   logic [2:0] slot;
   logic       bk;
   assign slot = bus_addr[SLOT_LSB +: 3];
   assign bk   = line_ctrl[7];

   AST_PUSH_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> $past(bus_wr && slot == 3'd0 && !bk)); // R3
   AST_POP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> $past(bus_rd && slot == 3'd0 && !bk)); // R3
   AST_NO_POP_BANKED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && slot == 3'd0 && bk) |=> !rx_pop); // R4
   AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && slot == 3'd0 && bk) |=> $stable(baud_div)); // R6
   AST_DIV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && slot == 3'd0 && bk) |=> baud_div[DATA_W-1:0] == $past(bus_wdata)); // R6
   AST_RXCLR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      rxf_clear |-> $past(bus_wr && slot == 3'd2 && !bk && bus_wdata[1])); // R7
   AST_TXCLR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      txf_clear |-> $past(bus_wr && slot == 3'd2 && !bk && bus_wdata[2])); // R7
   AST_FEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && slot == 3'd2 && !bk) |=> $stable(fifo_enable)); // R7
   AST_LCR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && slot == 3'd3) |=> line_ctrl == $past(bus_wdata)); // R9
   AST_RO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (slot == 3'd5 || slot == 3'd6)) |=>
         ($stable(int_enable) && $stable(line_ctrl) && $stable(modem_ctrl) &&
          $stable(alt_func) && $stable(fifo_enable) && !tx_push)); // R10

   if (RD_REG) begin : g_rd_hold
      AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_rd |=> $stable(bus_rdata)); // R11
   end

endmodule

bind uartreg_bank uartreg_bank_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .SLOT_LSB (SLOT_LSB),
   .RD_REG   (RD_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_wr      (bus_wr),
   .bus_rd      (bus_rd),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .rx_pop      (rx_pop),
   .tx_push     (tx_push),
   .rxf_clear   (rxf_clear),
   .txf_clear   (txf_clear),
   .fifo_enable (fifo_enable),
   .int_enable  (int_enable),
   .line_ctrl   (line_ctrl),
   .modem_ctrl  (modem_ctrl),
   .alt_func    (alt_func),
   .baud_div    (baud_div)
);

// File: tb/uartreg_bank_tb.sv
module uartreg_bank_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  rx_byte = '0;
   logic [7:0]  irq_id = '0;
   logic [7:0]  line_stat = '0;
   logic [7:0]  modem_stat = '0;
   logic        rx_pop, tx_push, rxf_clear, txf_clear, fifo_enable;
   logic [7:0]  tx_byte, int_enable, line_ctrl, modem_ctrl, alt_func;
   logic [15:0] baud_div;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // bench model
   logic [7:0]  m_ier, m_lcr, m_mcr, m_scr, m_afr, m_stage, m_txb, m_rdata;
   logic [15:0] m_div;
   logic        m_fen, e_push, e_pop, e_rclr, e_tclr;

   always #(CLK_PERIOD/2) clk = ~clk;

   uartreg_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_byte(rx_byte), .irq_id(irq_id),
      .line_stat(line_stat), .modem_stat(modem_stat), .rx_pop(rx_pop), .tx_push(tx_push),
      .tx_byte(tx_byte), .rxf_clear(rxf_clear), .txf_clear(txf_clear),
      .fifo_enable(fifo_enable), .int_enable(int_enable), .line_ctrl(line_ctrl),
      .modem_ctrl(modem_ctrl), .alt_func(alt_func), .baud_div(baud_div)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic [2:0] s, input logic dl);
      case (s)
         3'd0:    return dl ? m_div[7:0] : rx_byte;
         3'd1:    return dl ? m_stage : m_ier;
         3'd2:    return dl ? m_afr : irq_id;
         3'd3:    return m_lcr;
         3'd4:    return m_mcr;
         3'd5:    return line_stat;
         3'd6:    return modem_stat;
         default: return m_scr;
      endcase
   endfunction

   task automatic model_reset();
      m_ier = 0; m_lcr = 0; m_mcr = 0; m_scr = 0; m_afr = 0; m_stage = 0;
      m_txb = 0; m_rdata = 0; m_div = 0; m_fen = 0;
      e_push = 0; e_pop = 0; e_rclr = 0; e_tclr = 0;
   endtask

   task automatic cmp_all(input string tag);
      chk({tag, " rdata"},   bus_rdata,   m_rdata);
      chk({tag, " push"},    tx_push,     e_push);
      chk({tag, " pop"},     rx_pop,      e_pop);
      chk({tag, " rclr"},    rxf_clear,   e_rclr);
      chk({tag, " tclr"},    txf_clear,   e_tclr);
      chk({tag, " txbyte"},  tx_byte,     m_txb);
      chk({tag, " ier"},     int_enable,  m_ier);
      chk({tag, " lcr"},     line_ctrl,   m_lcr);
      chk({tag, " mcr"},     modem_ctrl,  m_mcr);
      chk({tag, " div"},     baud_div,    m_div);
      chk({tag, " fen"},     fifo_enable, m_fen);
      chk({tag, " afr"},     alt_func,    m_afr);
   endtask

   // one bus access; outputs are due one edge later
   task automatic acc(input logic [7:0] a, input bit w, input bit r, input logic [7:0] d);
      logic [2:0] s;
      logic       dl;
      @(negedge clk);
      bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
      s  = a[5:3];
      dl = m_lcr[7];
      e_push = 0; e_pop = 0; e_rclr = 0; e_tclr = 0;
      if (r) begin
         m_rdata = exp_rd(s, dl);
         if (s == 3'd0 && !dl) e_pop = 1;
      end
      if (w) begin
         case (s)
            3'd0: if (dl) m_div = {m_stage, d}; else begin m_txb = d; e_push = 1; end
            3'd1: if (dl) m_stage = d; else m_ier = d;
            3'd2: if (dl) m_afr = d;
                  else begin m_fen = d[0]; e_rclr = d[1]; e_tclr = d[2]; end
            3'd3: m_lcr = d;
            3'd4: m_mcr = d;
            3'd7: m_scr = d;
            default: ;
         endcase
      end
      @(posedge clk);
      #1;
      bus_wr = 0; bus_rd = 0;
   endtask

   task automatic idle();
      @(negedge clk);
      e_push = 0; e_pop = 0; e_rclr = 0; e_tclr = 0;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0c1a));
      model_reset();
      repeat (4) @(posedge clk);
      #1;
      cmp_all("R1");
      @(negedge clk);
      rst_n = 1'b1;

      // R5 interrupt enable, with aliased addresses (R2)
      acc(8'h08, 1, 0, 8'h0A); cmp_all("R5");
      acc(8'h0D, 0, 1, 8'h00); cmp_all("R2");
      acc(8'hCF, 1, 1, 8'h05); cmp_all("R2");
      acc(8'h09, 0, 1, 8'h00); cmp_all("R5");

      // R3 transmit push and receive pop, then strobes fall (R11)
      acc(8'h00, 1, 0, 8'h5A); cmp_all("R3");
      rx_byte = 8'h3C;
      acc(8'h00, 0, 1, 8'h00); cmp_all("R3");
      idle(); cmp_all("R11");

      // bank the divisor (R4, R6)
      acc(8'h18, 1, 0, 8'h80); cmp_all("R9");
      acc(8'h08, 1, 0, 8'h12); cmp_all("R6");
      chk("R6 hi-only div", baud_div, 16'h0000);
      chk("R5 ier kept", int_enable, 8'h05);
      acc(8'h00, 1, 0, 8'h34); cmp_all("R4");
      chk("R6 div loaded", baud_div, 16'h1234);
      acc(8'h00, 0, 1, 8'h00); cmp_all("R4");
      acc(8'h08, 0, 1, 8'h00); cmp_all("R5");

      // R8 alternate function in banked slot 2
      acc(8'h10, 1, 0, 8'h77); cmp_all("R8");
      acc(8'h10, 0, 1, 8'h00); cmp_all("R8");

      // R7 FIFO control and identification read
      acc(8'h18, 1, 0, 8'h03); cmp_all("R9");
      acc(8'h10, 1, 0, 8'h07); cmp_all("R7");
      acc(8'h10, 1, 0, 8'h02); cmp_all("R7");
      irq_id = 8'hC1;
      acc(8'h10, 0, 1, 8'h00); cmp_all("R7");
      idle(); cmp_all("R11");

      // R9 modem control and scratch
      acc(8'h20, 1, 0, 8'h02); cmp_all("R9");
      acc(8'h38, 1, 0, 8'hA5); cmp_all("R9");
      acc(8'h38, 0, 1, 8'h00); cmp_all("R9");

      // R10 read-only slots
      line_stat = 8'h60; modem_stat = 8'hB0;
      acc(8'h28, 1, 0, 8'hFF); cmp_all("R10");
      acc(8'h30, 1, 0, 8'hFF); cmp_all("R10");
      acc(8'h28, 0, 1, 8'h00); cmp_all("R10");
      acc(8'h30, 0, 1, 8'h00); cmp_all("R10");
      acc(8'h38, 0, 1, 8'h00); cmp_all("R10");

      // random mix of accesses (R2 decode across all slots and banks)
      for (int i = 0; i < 500; i++) begin
         logic [7:0] a;
         logic [7:0] d;
         bit w, r;
         a = 8'($urandom);
         d = 8'($urandom);
         w = ($urandom % 3) != 0;
         r = ($urandom % 2) != 0;
         rx_byte    = 8'($urandom);
         irq_id     = 8'($urandom);
         line_stat  = 8'($urandom);
         modem_stat = 8'($urandom);
         acc(a, w, r, d);
         cmp_all("R2");
         if (($urandom % 8) == 0) begin
            idle(); cmp_all("R11");
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule